// File: doc/BRIEF.md
# Shadow Return-Address Stack Checker

This block keeps a protected second copy of function return addresses and checks every return against it. A call event pushes the return address onto a downward-growing shadow stack. A return event carries the address taken from the ordinary program stack. The block pops the top shadow entry, compares the two and raises a control-protection fault when they differ.

Besides the call and return checks, the block accepts four more commands. An unwind command moves the pointer upward by up to 255 entries. A stack-switch command moves to another shadow stack held in the same storage, through an 8-byte-aligned restore token. A save-previous command leaves a token behind for the stack that was just left. A read command returns the current shadow pointer.

Storage is an internal array of 64-bit words inside a fixed byte window. The window starts at `BASE_ADDR` and holds `DEPTH` words. Its upper end is `TOP = BASE_ADDR + 8*DEPTH`. The shadow pointer is a byte address. Every violation freezes the block with a status code until software clears it.

Top module: `shadow_ret_stack`

## Requirements
- R1: After reset the shadow pointer equals TOP, `fault_code` is 0 and neither `fault_pulse` nor `result_valid` is high. The pointer always stays 8-byte aligned and within BASE..TOP.
- R2: A call (`cmd_op`=1) writes `cmd_arg` to pointer-8 and lowers the pointer by 8.
- R3: A return (`cmd_op`=2) compares `cmd_arg` with the word at the pointer. On a match the pointer rises by 8. On a mismatch the block faults with code 1 and the pointer is unchanged.
- R4: An unwind (`cmd_op`=3) raises the pointer by 8 times `cmd_arg[7:0]`, ignoring the upper argument bits. If the result would pass TOP, the block faults with code 5 instead.
- R5: A switch (`cmd_op`=4) takes the token address from `cmd_arg`. It is refused with the following codes:
  - code 3 if the address is not 8-byte aligned;
  - code 2 if the address lies outside the window;
  - code 2 if the token's bit 1 ("previous") is set;
  - code 2 if the token's bit 0 ("64-bit") is clear;
  - code 2 if the token's address field (bits 63:3) is not the token address plus 8.

  When accepted, the token is replaced by the old pointer with bits 1 and 0 set, and the pointer moves to the token address.
- R6: A save-previous (`cmd_op`=5) reads the token at the pointer. It needs bits 1 and 0 set, and its address field A must satisfy BASE+8 <= A <= TOP; otherwise the block faults with code 2 (code 5 if the pointer is at TOP). When accepted, it writes A with only bit 0 set to address A-8, then raises the pointer by 8.
- R7: A read (`cmd_op`=6) sets `result_valid` for one cycle in the next cycle, with `result_data` equal to the pointer.
- R8: A call when the pointer equals BASE faults with code 4 (overflow). A return when the pointer equals TOP faults with code 5 (underflow). Neither changes the pointer.
- R9: A fault pulses `fault_pulse` for one cycle and holds `fault_code` until `fault_clr`. While a fault is held, every command is ignored: no write, no pointer change, no result.
- R10: Opcodes 0 and 7 change nothing and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 64 | Return address, unwind count or token address |
| fault_clr | input | 1 | Clears a held fault |
| result_valid | output | 1 | Pointer read result valid |
| result_data | output | 64 | Pointer value returned by a read |
| fault_pulse | output | 1 | One-cycle pulse when a fault is raised |
| fault_code | output | 3 | Held fault status, 0 when none |

## Verification
The hardest situation to reach from the ports is a stack switch onto a valid token. No command writes a token directly. The stimulus therefore pushes, through an ordinary call, a word whose address field points just above its own slot and whose bit 0 is set. It then pushes more entries so the outgoing stack sits elsewhere before switching. A save-previous then leaves a second token. A switch back onto that token, followed by returns, proves the rewritten token contents word by word.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int WORD_W = 64;
    localparam int TOK_WIDE_BIT = 0;
    localparam int TOK_PREV_BIT = 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_CALL     = 3'd1,
        OP_RET      = 3'd2,
        OP_UNWIND   = 3'd3,
        OP_SWITCH   = 3'd4,
        OP_SAVEPREV = 3'd5,
        OP_READ     = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_RET   = 3'd1,
        FLT_TOKEN = 3'd2,
        FLT_ALIGN = 3'd3,
        FLT_OVER  = 3'd4,
        FLT_UNDER = 3'd5
    } flt_e;

    // outcome of one command, computed combinationally
    typedef struct packed {
        logic  we;
        word_t wr_addr;
        word_t wr_data;
        word_t ssp_nxt;
        flt_e  flt;
    } step_t;

    function automatic word_t tok_addr(input word_t t);
        return {t[WORD_W-1:3], 3'b000};
    endfunction

    function automatic word_t make_tok(input word_t a, input logic prev);
        return {a[WORD_W-1:3], 1'b0, prev, 1'b1};
    endfunction
endpackage

// File: rtl/ssc_store.sv
module ssc_store
    import ssc_pkg::*;
#(
    parameter int    DEPTH     = 32,
    parameter word_t BASE_ADDR = 64'h1000
) (
    input  logic  clk,
    input  word_t rd_addr,
    output word_t rd_data,
    input  logic  we,
    input  word_t wr_addr,
    input  word_t wr_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t         mem [DEPTH];
    word_t         rd_off, wr_off;
    logic [IW-1:0] rd_idx, wr_idx;

    always_comb begin
        rd_off = rd_addr - BASE_ADDR;
        wr_off = wr_addr - BASE_ADDR;
        rd_idx = rd_off[IW+2:3];
        wr_idx = wr_off[IW+2:3];
    end

    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
    import ssc_pkg::*;
#(
    parameter word_t BASE_ADDR = 64'h1000,
    parameter word_t TOP_ADDR  = 64'h1100
) (
    input  op_e   op,
    input  word_t arg,
    input  word_t ssp,
    input  word_t rd_data,
    output word_t rd_addr,
    output step_t step
);
    word_t span, old;

    always_comb begin
        step         = '0;
        step.ssp_nxt = ssp;
        step.flt     = FLT_NONE;
        rd_addr      = (op == OP_SWITCH) ? arg : ssp;
        span         = {{(WORD_W-11){1'b0}}, arg[7:0], 3'b000};
        old          = tok_addr(rd_data);
        unique case (op)
            OP_CALL: begin
                if (ssp == BASE_ADDR) step.flt = FLT_OVER;
                else begin
                    step.we      = 1'b1;
                    step.wr_addr = ssp - 64'd8;
                    step.wr_data = arg;
                    step.ssp_nxt = ssp - 64'd8;
                end
            end
            OP_RET: begin
                if (ssp == TOP_ADDR)     step.flt = FLT_UNDER;
                else if (rd_data != arg) step.flt = FLT_RET;
                else                     step.ssp_nxt = ssp + 64'd8;
            end
            OP_UNWIND: begin
                if ((TOP_ADDR - ssp) < span) step.flt = FLT_UNDER;
                else                         step.ssp_nxt = ssp + span;
            end
            OP_SWITCH: begin
                if (arg[2:0] != 3'b000)
                    step.flt = FLT_ALIGN;
                else if (arg < BASE_ADDR || arg >= TOP_ADDR)
                    step.flt = FLT_TOKEN;
                else if (rd_data[TOK_PREV_BIT] || !rd_data[TOK_WIDE_BIT]
                         || old != arg + 64'd8)
                    step.flt = FLT_TOKEN;
                else begin
                    step.we      = 1'b1;
                    step.wr_addr = arg;
                    step.wr_data = make_tok(ssp, 1'b1);
                    step.ssp_nxt = arg;
                end
            end
            OP_SAVEPREV: begin
                if (ssp == TOP_ADDR)
                    step.flt = FLT_UNDER;
                else if (!rd_data[TOK_PREV_BIT] || !rd_data[TOK_WIDE_BIT])
                    step.flt = FLT_TOKEN;
                else if (old < BASE_ADDR + 64'd8 || old > TOP_ADDR)
                    step.flt = FLT_TOKEN;
                else begin
                    step.we      = 1'b1;
                    step.wr_addr = old - 64'd8;
                    step.wr_data = make_tok(old, 1'b0);
                    step.ssp_nxt = ssp + 64'd8;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
    import ssc_pkg::*;
#(
    parameter int    DEPTH     = 32,
    parameter word_t BASE_ADDR = 64'h1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [63:0] cmd_arg,
    input  logic        fault_clr,
    output logic        result_valid,
    output logic [63:0] result_data,
    output logic        fault_pulse,
    output logic [2:0]  fault_code
);
    localparam word_t TOP_ADDR = BASE_ADDR + word_t'(DEPTH) * 64'd8;

    word_t ssp_q, rd_addr, rd_data;
    flt_e  flt_q;
    step_t step;
    op_e   op;
    logic  take;

    assign op   = op_e'(cmd_op);
    assign take = cmd_valid && (flt_q == FLT_NONE);

    ssc_ctrl #(.BASE_ADDR(BASE_ADDR), .TOP_ADDR(TOP_ADDR)) u_ctrl (
        .op(op), .arg(cmd_arg), .ssp(ssp_q), .rd_data(rd_data),
        .rd_addr(rd_addr), .step(step)
    );

    ssc_store #(.DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)) u_store (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .we(take && step.we), .wr_addr(step.wr_addr), .wr_data(step.wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ssp_q        <= TOP_ADDR;
            flt_q        <= FLT_NONE;
            fault_pulse  <= 1'b0;
            result_valid <= 1'b0;
            result_data  <= '0;
        end else begin
            fault_pulse  <= 1'b0;
            result_valid <= 1'b0;
            if (flt_q != FLT_NONE) begin
                if (fault_clr) flt_q <= FLT_NONE;
            end else if (take) begin
                if (step.flt != FLT_NONE) begin
                    flt_q       <= step.flt;
                    fault_pulse <= 1'b1;
                end else begin
                    ssp_q <= step.ssp_nxt;
                end
                if (op == OP_READ) begin
                    result_valid <= 1'b1;
                    result_data  <= ssp_q;
                end
            end
        end
    end

    assign fault_code = flt_q;
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
    parameter int          DEPTH     = 32,
    parameter logic [63:0] BASE_ADDR = 64'h1000
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        result_valid,
    input logic [63:0] result_data,
    input logic        fault_pulse,
    input logic [2:0]  fault_code,
    input logic [63:0] ssp_q
);
    localparam logic [63:0] TOP = BASE_ADDR + 64'(DEPTH) * 64'd8;

    // R1
    ptr_window_chk: assert property (@(posedge clk) disable iff (rst)
        ssp_q[2:0] == 3'b000 && ssp_q >= BASE_ADDR && ssp_q <= TOP);

    // R2
    call_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1 && fault_code == 3'd0 && ssp_q != BASE_ADDR)
        |=> ssp_q == $past(ssp_q) - 64'd8);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1 && fault_code == 3'd0 && ssp_q == BASE_ADDR)
        |=> fault_pulse && fault_code == 3'd4 && ssp_q == BASE_ADDR);

    // R7
    read_echo_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> result_data == $past(ssp_q));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0 && cmd_valid) |=> $stable(ssp_q) && !result_valid);

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    // R9
    pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> fault_code != 3'd0);
endmodule

bind shadow_ret_stack ssc_chk #(.DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .result_valid(result_valid), .result_data(result_data),
    .fault_pulse(fault_pulse), .fault_code(fault_code), .ssp_q(ssp_q)
);

// File: tb/shadow_ret_stack_tb.sv
module shadow_ret_stack_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h1000;
    localparam logic [63:0] TOP  = 64'h1100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_arg = '0;
    logic        fault_clr = 1'b0;
    logic        result_valid, fault_pulse;
    logic [63:0] result_data;
    logic [2:0]  fault_code;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit          is_flt;
        logic [63:0] val;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_ret_stack #(.DEPTH(32), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .fault_clr(fault_clr), .result_valid(result_valid),
        .result_data(result_data), .fault_pulse(fault_pulse), .fault_code(fault_code)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_val(input logic [63:0] v, input string tag);
        exp_q.push_back('{1'b0, v, tag});
    endtask

    task automatic exp_flt(input logic [2:0] c, input string tag);
        exp_q.push_back('{1'b1, {61'd0, c}, tag});
    endtask

    task automatic send(input logic [2:0] op, input logic [63:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic rd(input logic [63:0] v, input string tag);
        exp_val(v, tag);
        send(3'd6, 64'd0);
    endtask

    // monitor: pops the scoreboard as results and faults appear
    always @(negedge clk) begin
        if (!rst && (result_valid || fault_pulse)) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected event actual=%h/%0d expected=none",
                         result_data, fault_code);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (it.is_flt) begin
                    check({it.tag, " fault flag"}, {63'd0, fault_pulse}, 64'd1);
                    check({it.tag, " fault code"}, {61'd0, fault_code}, it.val);
                end else begin
                    check({it.tag, " result flag"}, {63'd0, result_valid}, 64'd1);
                    check({it.tag, " pointer"}, result_data, it.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 code", {61'd0, fault_code}, 64'd0);
        check("R1 pulse", {63'd0, fault_pulse}, 64'd0);
        check("R1 result", {63'd0, result_valid}, 64'd0);
        rd(TOP, "R1 reset ptr");

        // R2 push, R3 pop
        send(3'd1, 64'hAAAA0000);
        send(3'd1, 64'hBBBB0000);
        rd(64'h10F0, "R2");
        send(3'd2, 64'hBBBB0000);
        rd(64'h10F8, "R3 match");
        exp_flt(3'd1, "R3 mismatch");
        send(3'd2, 64'h1234);
        send(3'd6, 64'd0);          // ignored while faulted (R9)
        send(3'd1, 64'h99);         // ignored while faulted (R9)
        clear();
        rd(64'h10F8, "R9 frozen ptr");
        send(3'd2, 64'hAAAA0000);
        rd(TOP, "R3 second pop");

        // R8 underflow on return
        exp_flt(3'd5, "R8 underflow");
        send(3'd2, 64'd0);
        clear();

        // R10 no-op opcodes
        send(3'd7, 64'd5);
        send(3'd0, 64'd5);
        rd(TOP, "R10 nop");

        // R8 overflow
        for (int i = 0; i < 32; i++) send(3'd1, 64'hC000 + 64'(i));
        exp_flt(3'd4, "R8 overflow");
        send(3'd1, 64'hEEEE);
        clear();
        rd(BASE, "R8 ptr kept");
        send(3'd2, 64'hC01F);
        rd(64'h1008, "R8 pop after full");

        // R4 unwind
        send(3'd3, 64'd31);
        rd(TOP, "R4 unwind to top");
        send(3'd3, 64'd0);
        rd(TOP, "R4 unwind zero");
        exp_flt(3'd5, "R4 past top");
        send(3'd3, 64'd1);
        clear();
        for (int i = 0; i < 6; i++) send(3'd1, 64'h7000 + 64'(i));
        send(3'd3, 64'h105);
        rd(64'h10F8, "R4 low byte count");
        send(3'd2, 64'h7000);
        rd(TOP, "R4 entry after unwind");

        // R5 switch
        send(3'd1, 64'h1101);       // token at 0x10F8 -> 0x1100|wide
        send(3'd1, 64'hD000);
        send(3'd1, 64'hD100);       // outgoing pointer 0x10E8
        exp_flt(3'd3, "R5 misaligned");
        send(3'd4, 64'h10F4);
        clear();
        exp_flt(3'd2, "R5 bad address field");
        send(3'd4, 64'h10F0);
        clear();
        exp_flt(3'd2, "R5 outside window");
        send(3'd4, 64'h2000);
        clear();
        send(3'd4, 64'h10F8);
        rd(64'h10F8, "R5 switched");

        // R6 save previous: writes 0x10E9 at 0x10E0
        send(3'd5, 64'd0);
        rd(TOP, "R6 popped");
        exp_flt(3'd5, "R6 at top");
        send(3'd5, 64'd0);
        clear();
        send(3'd4, 64'h10E0);
        rd(64'h10E0, "R6 saved token usable");
        send(3'd2, 64'h1103);       // rewritten token content (R5)
        send(3'd2, 64'hD100);
        send(3'd2, 64'hD000);
        rd(64'h10F8, "R5 token rewrite");
        exp_flt(3'd2, "R5 previous flag");
        send(3'd4, 64'h10F8);
        clear();
        send(3'd1, 64'h5001);
        exp_flt(3'd2, "R6 no previous flag");
        send(3'd5, 64'd0);
        clear();
        rd(64'h10F0, "R6 ptr kept");
        send(3'd1, 64'h10F0);       // slot 0x10E8, wide bit clear
        exp_flt(3'd2, "R5 no wide flag");
        send(3'd4, 64'h10E8);
        clear();

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule